// File: doc/BRIEF.md
# RAM-Based Long Shift Register

This block delays a stream of fixed-width samples by a fixed number of shifts. It does not pass the samples through a chain of flip-flops. It writes each sample once into a memory that has one write port and one read port, and it moves two address counters around that memory. The data stays where it was written and only the pointers advance. That makes the block suitable for long delays, where a register chain would cost too much area.

Reset sets the read pointer to the first memory location and the write pointer to the last one. The write location therefore always trails the read location by exactly one, and this sets the delay. Each clock with the shift enable high does three things: it stores the incoming sample, it registers the sample read from the memory, and it advances both pointers. Both pointers wrap from the last location back to zero.

A valid flag marks the point after reset from which the output carries real data. Clocks with the shift enable low change nothing.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `dout_o` is all zeros and `valid_o` is 0.
- R2: Once `valid_o` is 1, the value on `dout_o` after the k-th shift since reset equals the `din_i` value presented with shift k-(DEPTH-1). A shift is a rising clock edge with `shift_i` high.
- R3: Reset places the read pointer at location 0 and the write pointer at location DEPTH-1. As a result, the first sample shifted in after reset first appears on `dout_o` on the DEPTH-th shift.
- R4: Both pointers wrap from DEPTH-1 back to 0, so the delay in R2 holds for runs longer than DEPTH shifts.
- R5: A clock edge with `shift_i` low writes nothing to the memory and advances no pointer. Both `dout_o` and `valid_o` hold their values. The `din_i` value present on that edge is never delivered to the output.
- R6: `valid_o` stays 0 for the first DEPTH-1 shifts after reset. It becomes 1 on the DEPTH-th shift and stays 1 until the next reset.
- R7: Asserting `rst_ni` during operation returns the block to the state in R1 and R3. After release, filling starts over from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | Shift enable; high advances the line by one sample |
| din_i | input | DATA_W | Sample entering the line |
| dout_o | output | DATA_W | Delayed sample, registered |
| valid_o | output | 1 | High once the line has been filled after reset |

## Verification
An incrementing sample sequence makes every sample distinct, so a delay that is one shift too long or too short shows up as a wrong value. Alternating and walking-one patterns expose stuck or swapped data bits. A pseudo-random stream run for several times DEPTH shifts exercises pointer wrap with no repeating pattern. Runs with stall clocks interleaved, during which `din_i` keeps changing, separate a design that gates writes and pointer moves correctly from one that captures samples while `shift_i` is low.

// File: rtl/ram_dl_pkg.sv
package ram_dl_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned DEPTH_DEF  = 16;

  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/rdl_ptr.sv
module rdl_ptr #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned RST_VAL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= ADDR_W'(RST_VAL);
    else if (adv_i) ptr_o <= ptr_o + 1'b1;  // natural wrap at 2**ADDR_W
  end

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ptr_o == ADDR_W'($past(ptr_o) + 1'b1));
  assert_ptr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/rdl_dpram.sv
module rdl_dpram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = ram_dl_pkg::addr_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  // registered read port; output register resets, array does not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_o <= '0;
    else if (re_i) rd_o <= mem_q[ra_i];
  end

  assert_no_collide_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && re_i) |-> wa_i != ra_i);
endmodule

// File: rtl/rdl_fill.sv
module rdl_fill #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = ram_dl_pkg::addr_bits(DEPTH) + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  output logic valid_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (shift_i && cnt_q != CNT_W'(DEPTH)) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == CNT_W'(DEPTH));

  assert_valid_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  assert_valid_on_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !shift_i |=> !valid_o);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
  parameter int unsigned DATA_W = ram_dl_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH  = ram_dl_pkg::DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              valid_o
);
  localparam int unsigned ADDR_W = ram_dl_pkg::addr_bits(DEPTH);

  logic [ADDR_W-1:0] rd_ptr, wr_ptr, ptr_gap;

  rdl_ptr #(.ADDR_W(ADDR_W), .RST_VAL(0)) u_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(shift_i), .ptr_o(rd_ptr)
  );

  rdl_ptr #(.ADDR_W(ADDR_W), .RST_VAL(DEPTH - 1)) u_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(shift_i), .ptr_o(wr_ptr)
  );

  rdl_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(shift_i), .wa_i(wr_ptr), .wd_i(din_i),
    .re_i(shift_i), .ra_i(rd_ptr), .rd_o(dout_o)
  );

  rdl_fill #(.DEPTH(DEPTH)) u_fill (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift_i), .valid_o(valid_o)
  );

  assign ptr_gap = rd_ptr - wr_ptr;

  assert_ptr_offset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_gap == ADDR_W'(1));
  assert_dout_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(dout_o) && $stable(valid_o));
  assert_no_data_early_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ptr_gap == ADDR_W'(1));
endmodule

// File: tb/sim_ram_delay_line.sv
`timescale 1ns/1ps
module sim_ram_delay_line;
  localparam int DW = 8;
  localparam int D  = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          shift_i = 1'b0;
  logic [DW-1:0] din_i = '0;
  logic [DW-1:0] dout_o;
  logic          valid_o;

  int n_chk = 0;
  int n_fail = 0;
  int s = 0;
  logic [DW-1:0] hist [0:4095];
  logic [DW-1:0] lfsr = 8'h5A;

  always #5 clk = ~clk;

  ram_delay_line #(.DATA_W(DW), .DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .shift_i(shift_i),
    .din_i(din_i), .dout_o(dout_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // entered at a negedge; leaves at the next negedge after checking
  task automatic step(input logic en, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] pd;
    logic pv;
    pd = dout_o;
    pv = valid_o;
    shift_i = en;
    din_i = d;
    if (en) begin
      hist[s] = d;
      s++;
    end
    @(negedge clk);
    if (en) begin
      chk(valid_o == (s >= D), {tag, " R6 valid"}, valid_o, (s >= D));
      if (s >= D) chk(dout_o == hist[s-D], {tag, " R2 data"}, dout_o, hist[s-D]);
    end else begin
      chk(dout_o == pd, {tag, " R5 dout hold"}, dout_o, pd);
      chk(valid_o == pv, {tag, " R5 valid hold"}, valid_o, pv);
    end
    shift_i = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    chk(dout_o == '0, {tag, " R1 dout in reset"}, dout_o, 0);
    chk(valid_o == 1'b0, {tag, " R1 valid in reset"}, valid_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    s = 0;
    @(negedge clk);
    chk(dout_o == '0, {tag, " R1 dout after release"}, dout_o, 0);
    chk(valid_o == 1'b0, {tag, " R1 valid after release"}, valid_o, 0);
  endtask

  task automatic t_fill_incr();
    for (int i = 0; i < D; i++) step(1'b1, DW'(i + 1), "fill R3");
    chk(dout_o == DW'(1), "R3 first sample on DEPTH-th shift", dout_o, 1);
    chk(valid_o == 1'b1, "R6 valid at DEPTH-th shift", valid_o, 1);
    for (int i = 0; i < D; i++) step(1'b1, DW'(8'h40 + i), "incr R2");
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 3 * D; i++) step(1'b1, (i % 2) ? 8'hAA : 8'h55, "alt R4");
  endtask

  task automatic t_walk();
    for (int i = 0; i < 2 * D; i++) step(1'b1, DW'(1) << (i % DW), "walk R2");
  endtask

  task automatic t_stall();
    for (int i = 0; i < 2 * D; i++) begin
      step(1'b1, DW'(8'h80 + i), "stall-run R5");
      if (i % 3 == 0) step(1'b0, 8'hEE, "stall R5");
      if (i % 5 == 0) begin
        step(1'b0, 8'h11, "stall R5");
        step(1'b0, 8'h22, "stall R5");
      end
    end
  endtask

  task automatic t_lfsr();
    for (int i = 0; i < 4 * D; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b1, lfsr, "lfsr R4");
    end
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 5; i++) step(1'b1, DW'(8'hC0 + i), "pre-reset R7");
    do_reset("R7");
    for (int i = 0; i < D - 1; i++) begin
      step(1'b1, DW'(8'hD0 + i), "refill R7");
      chk(valid_o == 1'b0, "R7 valid low during refill", valid_o, 0);
    end
    step(1'b1, 8'hDF, "refill R7");
    chk(dout_o == 8'hD0, "R7 first sample after re-reset", dout_o, 8'hD0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    do_reset("R1");
    t_fill_incr();
    t_alternate();
    t_walk();
    t_stall();
    t_lfsr();
    t_midreset();
    t_lfsr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule